// File: doc/BRIEF.md
# Interrupt Flag Aggregator with Command Register

This block gathers single-cycle event pulses into two banks of sticky interrupt flags and combines them into one active-low interrupt line for a host processor. Each flag has its own mask bit and one global mask sits in front of the line. A mask only stops a flag from driving the line; the flag itself is still recorded. Software acknowledges a flag by writing a one to its position. One flag in the first bank is also raised by a built-in detector that watches a two-bit cable orientation code and reports when it leaves the idle code.

The same register window holds a command register. Software writes requests into it. When several requests are written together, a fixed priority picks one winner. Every request except "disabled" lasts one clock and then clears itself. "Disabled" is a level that stays set until software writes it back to zero.

Register access is a flat address/data port with a write strobe and a combinational read path. Address map: 0 control (bit 0 = global mask), 1 mask A, 2 mask B, 3 flags A, 4 flags B, 5 command. Addresses 6 and 7 read as zero.

Top module: `irq_w1c_aggregator`

## Requirements
- R1: After reset the control register reads 01h, the masks, flags and command register read 00h, `irq_n` is 1, `cmd_pulse` is 0 and `cmd_disabled` is 0.
- R2: A high bit on `evt_a`/`evt_b` sets the matching implemented flag at the next clock edge, whatever the value of its own mask or the global mask.
- R3: Writing a flag register clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag stays set.
- R5: `irq_n` is 0 exactly when the global mask is 0 and at least one flag is set with its mask bit 0. It returns to 1 once every set flag is either cleared or masked.
- R6: Flag A bit 6 sets when `orient` was 00 on the previous clock and is now 01 or 10. It does not set on a change to 11, on a return to 00, or on a change between non-zero codes.
- R7: Command register bits are: 5 disabled, 4 error-recovery, 3 force-source, 2 force-sink, 1 unattached-source, 0 unattached-sink. If a write has bit 5 at 0, only the highest set bit among 4..0 is kept. That bit appears on `cmd_pulse` at the same position.
- R8: A kept request is on `cmd_pulse` and reads back in the command register for exactly the one cycle after the write, and then reads 0.
- R9: A command write with bit 5 at 1 sets `cmd_disabled` and produces no pulse. `cmd_disabled` stays 1 until a command write with bit 5 at 0.
- R10: Reserved bits read as 0 and ignore writes: control bits 7..1, command bits 7..6, bit 7 of both flag banks and both mask registers, and all of addresses 6 and 7.
- R11: While the global mask is 1, `irq_n` stays 1 even with unmasked flags pending. Clearing the global mask drives `irq_n` low in the cycle after the write. Setting it again releases the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_a | input | 8 | Event pulses for flag bank A |
| evt_b | input | 8 | Event pulses for flag bank B |
| orient | input | 2 | Cable orientation code watched by the edge detector |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_n | output | 1 | Interrupt line, low = asserted (open-drain style) |
| cmd_disabled | output | 1 | Sticky disabled request |
| cmd_pulse | output | 5 | One-cycle winning command request, one-hot or zero |

## Verification
The bench first checks that masked flags still latch. A design that gated the flag with its mask would lose the event, and the flag would read back zero. It then races an event against an acknowledge of the same bit; if the clear won, the event would be lost without trace. It holds events back behind the global mask and then releases it, which catches a line that never falls or falls too early. It walks the orientation code through every transition, so an edge detector that fires on 11 or on the return to idle would raise a false flag. It writes several command bits together, which exposes a wrong priority order, a pulse that lingers more than one cycle, or a disabled level that clears by itself.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   // register addresses
   localparam int unsigned REG_CTRL   = 0;
   localparam int unsigned REG_MASK_A = 1;
   localparam int unsigned REG_MASK_B = 2;
   localparam int unsigned REG_FLAG_A = 3;
   localparam int unsigned REG_FLAG_B = 4;
   localparam int unsigned REG_CMD    = 5;

   // command request positions, higher index wins
   localparam int unsigned CMD_UNATT_SNK = 0;
   localparam int unsigned CMD_UNATT_SRC = 1;
   localparam int unsigned CMD_FORCE_SNK = 2;
   localparam int unsigned CMD_FORCE_SRC = 3;
   localparam int unsigned CMD_ERR_REC   = 4;
   localparam int unsigned CMD_PULSES    = 5;
   localparam int unsigned CMD_DIS_BIT   = CMD_PULSES;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned      W    = 8,
   parameter logic [W-1:0]     IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic         mask_wr_i,
   input  logic         flag_wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] flag_o,
   output logic [W-1:0] mask_o,
   output logic         pend_o
);
   logic [W-1:0] flag_q, mask_q, clr_vec, flag_d;

   assign clr_vec = flag_wr_i ? wdata_i : '0;
   // events are ORed in after the clear so a same-cycle event survives
   assign flag_d  = ((flag_q & ~clr_vec) | evt_i) & IMPL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         mask_q <= '0;
      end else begin
         flag_q <= flag_d;
         if (mask_wr_i) mask_q <= wdata_i & IMPL;
      end
   end

   assign flag_o = flag_q;
   assign mask_o = mask_q;
   assign pend_o = |(flag_q & ~mask_q);

   for (genvar k = 0; k < W; k++) begin : g_bit_chk
      if (IMPL[k]) begin : g_impl
         assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[k] |=> flag_q[k]);
         assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_wr_i && wdata_i[k] && !evt_i[k]) |=> !flag_q[k]);
         assert_w0_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[k] && !(flag_wr_i && wdata_i[k])) |=> flag_q[k]);
         assert_event_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_wr_i && wdata_i[k] && evt_i[k]) |=> flag_q[k]);
      end
   end
endmodule

// File: rtl/orient_edge_det.sv
module orient_edge_det #(
   parameter int unsigned OW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [OW-1:0] orient_i,
   output logic          evt_o
);
   logic [OW-1:0] prev_q;
   logic          cur_single;

   // plain sampling flop: the previous code is whatever was seen last clock
   always_ff @(posedge clk) prev_q <= orient_i;

   always_comb begin
      int unsigned ones;
      ones = 0;
      for (int i = 0; i < OW; i++) ones += int'(orient_i[i]);
      cur_single = (ones == 1);
   end

   assign evt_o = (prev_q == '0) && cur_single;

   assert_orient_from_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(orient_i) != '0) |-> !evt_o);
   assert_orient_not_multi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(orient_i) != 1) |-> !evt_o);
endmodule

// File: rtl/cmd_resolver.sv
module cmd_resolver #(
   parameter int unsigned NP = 5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_i,
   input  logic [NP:0] cmd_i,
   output logic        disabled_o,
   output logic [NP-1:0] pulse_o
);
   logic [NP-1:0] win;
   logic          disabled_q;
   logic [NP-1:0] pulse_q;

   always_comb begin
      logic found;
      found = 1'b0;
      win   = '0;
      for (int i = NP - 1; i >= 0; i--) begin
         if (cmd_i[i] && !found) begin
            win[i] = 1'b1;
            found  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disabled_q <= 1'b0;
         pulse_q    <= '0;
      end else if (wr_i) begin
         disabled_q <= cmd_i[NP];
         pulse_q    <= cmd_i[NP] ? '0 : win;
      end else begin
         pulse_q    <= '0;
      end
   end

   assign disabled_o = disabled_q;
   assign pulse_o    = pulse_q;

   assert_cmd_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pulse_q));
   assert_cmd_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((|pulse_q) && !wr_i) |=> (pulse_q == '0));
   assert_disabled_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (disabled_q && !wr_i) |=> disabled_q);
   assert_disabled_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && cmd_i[NP]) |=> (disabled_q && pulse_q == '0));
endmodule

// File: rtl/irq_w1c_aggregator.sv
module irq_w1c_aggregator
   import irq_agg_pkg::*;
#(
   parameter int unsigned          DATA_W     = 8,
   parameter int unsigned          ADDR_W     = 3,
   parameter logic [DATA_W-1:0]    IMPL_A     = 8'h7F,
   parameter logic [DATA_W-1:0]    IMPL_B     = 8'h7F,
   parameter int unsigned          ORIENT_W   = 2,
   parameter int unsigned          ORIENT_BIT = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DATA_W-1:0]     evt_a,
   input  logic [DATA_W-1:0]     evt_b,
   input  logic [ORIENT_W-1:0]   orient,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  irq_n,
   output logic                  cmd_disabled,
   output logic [CMD_PULSES-1:0] cmd_pulse
);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_MASK_A = ADDR_W'(REG_MASK_A);
   localparam logic [ADDR_W-1:0] A_MASK_B = ADDR_W'(REG_MASK_B);
   localparam logic [ADDR_W-1:0] A_FLAG_A = ADDR_W'(REG_FLAG_A);
   localparam logic [ADDR_W-1:0] A_FLAG_B = ADDR_W'(REG_FLAG_B);
   localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(REG_CMD);

   // elaboration checks
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too small for the register window");
   end
   if (CMD_PULSES + 1 > DATA_W) begin : g_bad_cmd
      $error("command register does not fit in DATA_W");
   end
   if (ORIENT_BIT >= DATA_W) begin : g_bad_obit
      $error("ORIENT_BIT outside bank A");
   end else if (!IMPL_A[ORIENT_BIT]) begin : g_bad_oimpl
      $error("ORIENT_BIT must be an implemented flag");
   end

   logic wr_ctrl, wr_mask_a, wr_mask_b, wr_flag_a, wr_flag_b, wr_cmd;
   assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
   assign wr_mask_a = bus_wr && (bus_addr == A_MASK_A);
   assign wr_mask_b = bus_wr && (bus_addr == A_MASK_B);
   assign wr_flag_a = bus_wr && (bus_addr == A_FLAG_A);
   assign wr_flag_b = bus_wr && (bus_addr == A_FLAG_B);
   assign wr_cmd    = bus_wr && (bus_addr == A_CMD);

   logic gmask_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gmask_q <= 1'b1;
      else if (wr_ctrl) gmask_q <= bus_wdata[0];
   end

   logic              orient_evt;
   logic [DATA_W-1:0] evt_a_all;
   logic [DATA_W-1:0] flag_a, flag_b, mask_a, mask_b;
   logic              pend_a, pend_b;

   orient_edge_det #(.OW(ORIENT_W)) u_orient (
      .clk      (clk),
      .rst_n    (rst_n),
      .orient_i (orient),
      .evt_o    (orient_evt)
   );

   assign evt_a_all = evt_a | (DATA_W'(orient_evt) << ORIENT_BIT);

   irq_flag_bank #(.W(DATA_W), .IMPL(IMPL_A)) u_bank_a (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_a_all),
      .mask_wr_i (wr_mask_a),
      .flag_wr_i (wr_flag_a),
      .wdata_i   (bus_wdata),
      .flag_o    (flag_a),
      .mask_o    (mask_a),
      .pend_o    (pend_a)
   );

   irq_flag_bank #(.W(DATA_W), .IMPL(IMPL_B)) u_bank_b (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_b),
      .mask_wr_i (wr_mask_b),
      .flag_wr_i (wr_flag_b),
      .wdata_i   (bus_wdata),
      .flag_o    (flag_b),
      .mask_o    (mask_b),
      .pend_o    (pend_b)
   );

   cmd_resolver #(.NP(CMD_PULSES)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (wr_cmd),
      .cmd_i      (bus_wdata[CMD_PULSES:0]),
      .disabled_o (cmd_disabled),
      .pulse_o    (cmd_pulse)
   );

   assign irq_n = ~((pend_a | pend_b) & ~gmask_q);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL:   bus_rdata[0] = gmask_q;
         A_MASK_A: bus_rdata = mask_a;
         A_MASK_B: bus_rdata = mask_b;
         A_FLAG_A: bus_rdata = flag_a;
         A_FLAG_B: bus_rdata = flag_b;
         A_CMD:    bus_rdata[CMD_PULSES:0] = {cmd_disabled, cmd_pulse};
         default:  bus_rdata = '0;
      endcase
   end

   assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> ((flag_a | flag_b) != '0));
   assert_gmask_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[0]) |=> irq_n);
   assert_orient_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      orient_evt |=> flag_a[ORIENT_BIT]);
endmodule

// File: tb/test_irq_w1c_aggregator.sv
`timescale 1ns/1ps
module test_irq_w1c_aggregator;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] evt_a = '0, evt_b = '0;
   logic [1:0] orient = '0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq_n, cmd_disabled;
   logic [4:0] cmd_pulse;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_w1c_aggregator i_irq_w1c_aggregator (
      .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .evt_b(evt_b), .orient(orient),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_n(irq_n), .cmd_disabled(cmd_disabled),
      .cmd_pulse(cmd_pulse)
   );

   localparam logic [2:0] A_CTRL = 0, A_MA = 1, A_MB = 2, A_FA = 3, A_FB = 4, A_CMD = 5;

   // fields: evt_a evt_b mask_a mask_b gmask clr_a clr_b exp_a exp_b exp_irq_n
   localparam int NV = 7;
   localparam logic [79:0] VEC [NV] = '{
      80'h01_00_00_00_00_00_00_01_00_00,
      80'h00_81_00_00_00_00_00_00_01_00,
      80'h0F_F0_0F_F0_00_00_00_0F_70_01,
      80'hFF_FF_00_00_01_00_00_7F_7F_01,
      80'h3C_00_00_00_00_0C_00_30_00_00,
      80'h3C_00_30_00_00_0C_00_30_00_01,
      80'h12_24_00_00_00_12_24_00_00_01
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic pulse(input logic [7:0] a, input logic [7:0] b);
      @(negedge clk);
      evt_a = a; evt_b = b;
      @(negedge clk);
      evt_a = '0; evt_b = '0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(1);

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         chk($sformatf("R1 reset addr %0d", a), d, (a == 0) ? 8'h01 : 8'h00);
      end
      chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
      chk("R1 cmd outputs", {2'b0, cmd_disabled, cmd_pulse}, 8'h00);

      // vector table: R2 R3 R5 R10
      for (int v = 0; v < NV; v++) begin
         logic [79:0] t;
         t = VEC[v];
         wr(A_CTRL, 8'h01);
         wr(A_FA, 8'hFF); wr(A_FB, 8'hFF);
         wr(A_MA, t[63:56]); wr(A_MB, t[55:48]);
         pulse(t[79:72], t[71:64]);
         wr(A_FA, t[39:32]); wr(A_FB, t[31:24]);
         wr(A_CTRL, t[47:40]);
         rd(A_FA, d); chk($sformatf("R2/R3 vec %0d flags A", v), d, t[23:16]);
         rd(A_FB, d); chk($sformatf("R2/R3/R10 vec %0d flags B", v), d, t[15:8]);
         chk($sformatf("R5 vec %0d irq_n", v), {7'b0, irq_n}, t[7:0]);
      end

      // R10 reserved bits
      wr(A_CTRL, 8'hFF); rd(A_CTRL, d); chk("R10 ctrl reserved", d, 8'h01);
      wr(A_MA, 8'hFF);   rd(A_MA, d);   chk("R10 mask A bit 7", d, 8'h7F);
      wr(A_MB, 8'h80);   rd(A_MB, d);   chk("R10 mask B bit 7", d, 8'h00);
      wr(3'd6, 8'hFF);   rd(3'd6, d);   chk("R10 addr 6", d, 8'h00);
      wr(3'd7, 8'hFF);   rd(3'd7, d);   chk("R10 addr 7", d, 8'h00);
      wr(A_MA, 8'h00);

      // R3 write zero keeps, R4 event beats clear
      wr(A_FA, 8'hFF);
      pulse(8'h05, 8'h00);
      wr(A_FA, 8'h00); rd(A_FA, d); chk("R3 write 0 keeps", d, 8'h05);
      @(negedge clk);
      evt_a = 8'h01; bus_wr = 1'b1; bus_addr = A_FA; bus_wdata = 8'h05;
      @(negedge clk);
      evt_a = 8'h00; bus_wr = 1'b0;
      rd(A_FA, d); chk("R4 event wins over clear", d, 8'h01);
      wr(A_FA, 8'hFF);

      // R11 global mask hold-off and release, R5 masking
      wr(A_CTRL, 8'h01);
      pulse(8'h00, 8'h02);
      chk("R11 held while gmask set", {7'b0, irq_n}, 8'h01);
      rd(A_FB, d); chk("R2 flag set under gmask", d, 8'h02);
      wr(A_CTRL, 8'h00); chk("R11 low after gmask clear", {7'b0, irq_n}, 8'h00);
      wr(A_MB, 8'h02);   chk("R5 released when masked", {7'b0, irq_n}, 8'h01);
      wr(A_MB, 8'h00);   chk("R5 low when unmasked", {7'b0, irq_n}, 8'h00);
      wr(A_CTRL, 8'h01); chk("R11 gmask set releases", {7'b0, irq_n}, 8'h01);
      wr(A_CTRL, 8'h00);
      wr(A_FB, 8'h02);   chk("R5 released when cleared", {7'b0, irq_n}, 8'h01);

      // R6 orientation edges
      wr(A_FA, 8'hFF);
      @(negedge clk); orient = 2'b11; wait_cyc(2);
      rd(A_FA, d); chk("R6 00->11 no flag", d & 8'h40, 8'h00);
      orient = 2'b00; wait_cyc(2);
      rd(A_FA, d); chk("R6 11->00 no flag", d & 8'h40, 8'h00);
      orient = 2'b01; wait_cyc(2);
      rd(A_FA, d); chk("R6 00->01 flag", d & 8'h40, 8'h40);
      wr(A_FA, 8'h40);
      orient = 2'b00; wait_cyc(2);
      rd(A_FA, d); chk("R6 01->00 no flag", d & 8'h40, 8'h00);
      orient = 2'b10; wait_cyc(2);
      rd(A_FA, d); chk("R6 00->10 flag", d & 8'h40, 8'h40);
      wr(A_FA, 8'h40);
      orient = 2'b11; wait_cyc(2);
      rd(A_FA, d); chk("R6 10->11 no flag", d & 8'h40, 8'h00);
      orient = 2'b00; wait_cyc(2);
      wr(A_CTRL, 8'h01);

      // R7 R8 R9 command register
      wr(A_CMD, 8'h3E);
      chk("R9 disabled wins, no pulse", {2'b0, cmd_disabled, cmd_pulse}, 8'h20);
      wait_cyc(3);
      rd(A_CMD, d); chk("R9 disabled sticky", d, 8'h20);
      wr(A_CMD, 8'h1C);
      rd(A_CMD, d); chk("R7 error-recovery wins", d, 8'h10);
      chk("R7 pulse output", {3'b0, cmd_pulse}, 8'h10);
      wait_cyc(1);
      rd(A_CMD, d); chk("R8 self-clear", d, 8'h00);
      wr(A_CMD, 8'h0C); rd(A_CMD, d); chk("R7 force-source over force-sink", d, 8'h08);
      wr(A_CMD, 8'h06); rd(A_CMD, d); chk("R7 force-sink over unattached-source", d, 8'h04);
      wr(A_CMD, 8'h03); rd(A_CMD, d); chk("R7 unattached-source over unattached-sink", d, 8'h02);
      wr(A_CMD, 8'h01); rd(A_CMD, d); chk("R7 unattached-sink alone", d, 8'h01);
      wr(A_CMD, 8'hC8); rd(A_CMD, d); chk("R10 cmd reserved ignored", d, 8'h08);
      wait_cyc(1);
      chk("R8 pulse gone", {3'b0, cmd_pulse}, 8'h00);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule